// File: doc/BRIEF.md
# Accumulator ALU with Condition Evaluator

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator value, one operand byte and a 3-bit operation code, and it presents the new accumulator value on a combinational output. It also computes sign, zero, parity and carry for that operation and loads them into a flag register on the next clock edge while the flag enable is high. A hidden half-carry bit is kept alongside the flags. Only the decimal-adjust command reads it.

A decimal-adjust command input overrides the operation code. It corrects the accumulator after a binary addition of two packed-BCD bytes. A separate 3-bit condition code is evaluated against the stored flags, and the block returns one bit that tells a sequencer whether a conditional branch is taken. Instruction fetch, operand selection and the register file live outside the block. The operation code is the 3-bit field a decoder pulls from bits 5:3 of a register-operand arithmetic opcode, which has the form 10ooosss; adding register B is therefore 80H.

Top module: `acc_alu`

## Requirements
- R1: Operation code 000 returns acc + opd and 001 returns acc + opd + stored carry. The carry out of bit 7 becomes the new carry.
- R2: Operation codes 010 (acc − opd) and 011 (acc − opd − stored carry) return the difference and put the borrow into carry. Code 111 performs the same subtraction as 010 for the flags, but res_o equals acc_i.
- R3: Operation codes 100 (AND), 101 (XOR) and 110 (OR) return the bitwise result and always clear carry.
- R4: Zero is set when the 8-bit flag result is 00H. Sign copies its bit 7. Parity is set when it has an even number of one bits. For compare, the flag result is the difference.
- R5: cond_ok_o follows cond_i using the stored flags: 000 zero clear, 001 zero set, 010 carry clear, 011 carry set, 100 parity clear, 101 parity set, 110 sign clear, 111 sign set.
- R6: The flags load on a rising clock edge only when flag_we_i is high. Otherwise they hold their value.
- R7: An active-low reset clears sign, zero, parity, carry and the half-carry.
- R8: Decimal adjust adds 06H when the low nibble of acc_i exceeds 9 or the stored half-carry is set. The half-carry is set by a carry out of bit 3 on add, and by a borrow into bit 3 on subtract.
- R9: Decimal adjust then adds 60H if the partial result has an upper nibble above 9, overflowed past bit 7, or the stored carry is set. Carry becomes 1 exactly when this correction is applied.
- R10: While dec_adj_i is high, op_i has no effect on res_o or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Current accumulator |
| opd_i | input | 8 | Operand byte |
| op_i | input | 3 | Operation code |
| dec_adj_i | input | 1 | Decimal-adjust command, overrides op_i |
| flag_we_i | input | 1 | Load flags on next edge |
| cond_i | input | 3 | Branch-condition code |
| res_o | output | 8 | New accumulator value |
| sign_o | output | 1 | Stored sign flag |
| zero_o | output | 1 | Stored zero flag |
| parity_o | output | 1 | Stored parity flag (even) |
| carry_o | output | 1 | Stored carry / borrow flag |
| cond_ok_o | output | 1 | Selected condition holds |

## Verification
The bench builds the block with its single parameter at the default data width of 8. At that width the nibble boundaries used by decimal adjust fall at bits 3 and 7. This puts the low-nibble fix, the high-nibble fix, the overflow past bit 7 and the carry-driven fix all within reach of hand-computed byte values. At that width, every condition code is also checked against every flag pattern that the vector table leaves behind.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  input  logic [2:0]    op_i,
  input  logic          dec_adj_i,
  input  logic          flag_we_i,
  input  logic [2:0]    cond_i,
  output logic [DW-1:0] res_o,
  output logic          sign_o,
  output logic          zero_o,
  output logic          parity_o,
  output logic          carry_o,
  output logic          cond_ok_o
);
  localparam int NW = 4;
  localparam logic [DW:0]   LO_FIX = (DW+1)'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(6) << (DW - NW);
  localparam logic [NW-1:0] NINE   = NW'(9);

  logic s_q, z_q, p_q, c_q, h_q;

  // arithmetic path shared by add, subtract and compare
  logic          is_cmp, is_arith, is_sub, cin;
  logic [DW-1:0] b_x;
  logic [DW:0]   sum;
  logic [NW:0]   hsum;
  logic          ar_c, ar_h;

  assign is_cmp   = (op_i == 3'b111);
  assign is_arith = ~op_i[2] | is_cmp;
  assign is_sub   = op_i[1];
  assign cin      = is_sub ? ~(op_i[0] & ~op_i[2] & c_q) : (op_i[0] & c_q);
  assign b_x      = is_sub ? ~opd_i : opd_i;
  assign sum      = {1'b0, acc_i} + {1'b0, b_x} + {{DW{1'b0}}, cin};
  assign hsum     = {1'b0, acc_i[NW-1:0]} + {1'b0, b_x[NW-1:0]} + {{NW{1'b0}}, cin};
  assign ar_c     = is_sub ? ~sum[DW] : sum[DW];
  assign ar_h     = is_sub ? ~hsum[NW] : hsum[NW];

  // bitwise path
  logic [DW-1:0] lg_res;
  always_comb begin
    case (op_i[1:0])
      2'b00:   lg_res = acc_i & opd_i;
      2'b01:   lg_res = acc_i ^ opd_i;
      default: lg_res = acc_i | opd_i;
    endcase
  end

  // decimal adjust path
  logic          lo_big, lo_fix, hi_fix;
  logic [DW:0]   t1;
  logic [DW-1:0] da_res;

  assign lo_big = acc_i[NW-1:0] > NINE;
  assign lo_fix = lo_big | h_q;
  assign t1     = {1'b0, acc_i} + (lo_fix ? LO_FIX : '0);
  assign hi_fix = t1[DW] | (t1[DW-1:DW-NW] > NINE) | c_q;
  assign da_res = t1[DW-1:0] + (hi_fix ? HI_FIX : '0);

  // flag result selection
  logic [DW-1:0] f_res;
  logic          f_c, f_h;

  always_comb begin
    if (dec_adj_i) begin
      f_res = da_res;
      f_c   = hi_fix;
      f_h   = lo_fix & lo_big;
    end else if (is_arith) begin
      f_res = sum[DW-1:0];
      f_c   = ar_c;
      f_h   = ar_h;
    end else begin
      f_res = lg_res;
      f_c   = 1'b0;
      f_h   = 1'b0;
    end
  end

  assign res_o = (!dec_adj_i && is_cmp) ? acc_i : f_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      z_q <= 1'b0;
      p_q <= 1'b0;
      c_q <= 1'b0;
      h_q <= 1'b0;
    end else if (flag_we_i) begin
      s_q <= f_res[DW-1];
      z_q <= (f_res == '0);
      p_q <= ~^f_res;
      c_q <= f_c;
      h_q <= f_h;
    end
  end

  assign sign_o   = s_q;
  assign zero_o   = z_q;
  assign parity_o = p_q;
  assign carry_o  = c_q;

  always_comb begin
    case (cond_i[2:1])
      2'b00:   cond_ok_o = z_q ~^ cond_i[0];
      2'b01:   cond_ok_o = c_q ~^ cond_i[0];
      2'b10:   cond_ok_o = p_q ~^ cond_i[0];
      default: cond_ok_o = s_q ~^ cond_i[0];
    endcase
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] opd_i,
  input logic [2:0]    op_i,
  input logic          dec_adj_i,
  input logic          flag_we_i,
  input logic [2:0]    cond_i,
  input logic [DW-1:0] res_o,
  input logic          sign_o,
  input logic          zero_o,
  input logic          parity_o,
  input logic          carry_o,
  input logic          cond_ok_o
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable({sign_o, zero_o, parity_o, carry_o}));

  p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && !dec_adj_i && op_i[2] && op_i != 3'b111) |=> !carry_o);

  p_cmp_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_adj_i && op_i == 3'b111) |-> res_o == acc_i);

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (dec_adj_i || op_i != 3'b111)) |=> zero_o == ($past(res_o) == '0));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (dec_adj_i || op_i != 3'b111)) |=> sign_o == $past(res_o[DW-1]));

  p_cond_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 3'b001) |-> cond_ok_o == zero_o);

  p_cond_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == 3'b111) |-> cond_ok_o == sign_o);

  p_daa_keep_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && dec_adj_i && carry_o) |=> carry_o);
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_i = '0, opd_i = '0;
  logic [2:0] op_i = '0, cond_i = '0;
  logic       dec_adj_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] res_o;
  logic       sign_o, zero_o, parity_o, carry_o, cond_ok_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acc_alu u0 (.clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opd_i(opd_i), .op_i(op_i),
              .dec_adj_i(dec_adj_i), .flag_we_i(flag_we_i), .cond_i(cond_i),
              .res_o(res_o), .sign_o(sign_o), .zero_o(zero_o), .parity_o(parity_o),
              .carry_o(carry_o), .cond_ok_o(cond_ok_o));

  // {carry_in, op, acc, opd, expected res, expected {s,z,p,c}}
  localparam logic [31:0] VEC [12] = '{
    {1'b0, 3'd0, 8'h3A, 8'h25, 8'h5F, 4'b0010},
    {1'b0, 3'd0, 8'h80, 8'h80, 8'h00, 4'b0111},
    {1'b1, 3'd1, 8'h10, 8'h20, 8'h31, 4'b0000},
    {1'b0, 3'd2, 8'h05, 8'h07, 8'hFE, 4'b1001},
    {1'b1, 3'd3, 8'h10, 8'h0F, 8'h00, 4'b0110},
    {1'b1, 3'd4, 8'hF0, 8'h3C, 8'h30, 4'b0010},
    {1'b1, 3'd5, 8'hAA, 8'hAA, 8'h00, 4'b0110},
    {1'b0, 3'd6, 8'h81, 8'h02, 8'h83, 4'b1000},
    {1'b0, 3'd7, 8'h40, 8'h41, 8'h40, 4'b1011},
    {1'b1, 3'd7, 8'h22, 8'h22, 8'h22, 4'b0110},
    {1'b1, 3'd1, 8'hFF, 8'h00, 8'h00, 4'b0111},
    {1'b0, 3'd2, 8'h80, 8'h01, 8'h7F, 4'b0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic daa, input logic we);
    @(negedge clk);
    op_i = op; acc_i = a; opd_i = b; dec_adj_i = daa; flag_we_i = we;
  endtask

  task automatic latch;
    @(negedge clk);
    flag_we_i = 1'b0; dec_adj_i = 1'b0;
    #1;
  endtask

  task automatic preset_carry(input logic c);
    if (c) run_op(3'd0, 8'hFF, 8'h01, 1'b0, 1'b1);
    else   run_op(3'd4, 8'h00, 8'h00, 1'b0, 1'b1);
    latch();
  endtask

  function automatic logic [3:0] fl;
    return {sign_o, zero_o, parity_o, carry_o};
  endfunction

  task automatic check_conds(input logic [3:0] f, input string req);
    for (int k = 0; k < 8; k++) begin
      logic e, sel;
      cond_i = 3'(k);
      #1;
      case (k / 2)
        0: sel = f[2];
        1: sel = f[0];
        2: sel = f[1];
        default: sel = f[3];
      endcase
      e = (k % 2 == 1) ? sel : ~sel;
      chk(cond_ok_o == e, req, {31'b0, cond_ok_o}, {31'b0, e});
    end
  endtask

  task automatic daa_case(input logic [7:0] a, input logic [7:0] b, input logic [7:0] er,
                          input logic [3:0] ef, input string req);
    run_op(3'd0, a, b, 1'b0, 1'b1);
    latch();
    // R10: op_i set to compare, must be ignored while adjusting
    run_op(3'd7, res_o, 8'h55, 1'b1, 1'b1);
    #1;
    chk(res_o == er, req, {24'b0, res_o}, {24'b0, er});
    latch();
    chk(fl() == ef, req, {28'b0, fl()}, {28'b0, ef});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(fl() == 4'b0000, "R7 reset flags", {28'b0, fl()}, 0);
    cond_i = 3'd0; #1;
    chk(cond_ok_o == 1'b1, "R5 not-zero after reset", {31'b0, cond_ok_o}, 1);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 table
    for (int i = 0; i < 12; i++) begin
      logic [31:0] v;
      v = VEC[i];
      preset_carry(v[31]);
      run_op(v[30:28], v[27:20], v[19:12], 1'b0, 1'b1);
      #1;
      chk(res_o == v[11:4], "R1 R2 R3 result", {24'b0, res_o}, {24'b0, v[11:4]});
      latch();
      chk(fl() == v[3:0], "R4 flags", {28'b0, fl()}, {28'b0, v[3:0]});
      check_conds(v[3:0], "R5 condition");
    end

    // R6: flags hold while enable low (flags now 0000, AND 00 would set zero)
    run_op(3'd4, 8'h00, 8'h00, 1'b0, 1'b0);
    latch();
    chk(fl() == 4'b0000, "R6 hold", {28'b0, fl()}, 0);
    run_op(3'd0, 8'hFF, 8'h01, 1'b0, 1'b0);
    latch();
    chk(carry_o == 1'b0, "R6 hold carry", {31'b0, carry_o}, 0);

    // R8 R9 R10 decimal adjust
    daa_case(8'h38, 8'h45, 8'h83, 4'b1000, "R8 low nibble fix");
    daa_case(8'h29, 8'h19, 8'h48, 4'b0010, "R8 half-carry fix");
    daa_case(8'h99, 8'h01, 8'h00, 4'b0111, "R9 upper nibble fix");
    daa_case(8'h90, 8'h90, 8'h80, 4'b1001, "R9 carry-driven fix");
    daa_case(8'h12, 8'h34, 8'h46, 4'b0000, "R10 no fix needed");

    // R7: reset mid-run
    preset_carry(1'b1);
    rst_n = 1'b0; #1;
    chk(fl() == 4'b0000, "R7 async clear", {28'b0, fl()}, 0);
    @(negedge clk); rst_n = 1'b1;
    // half-carry also cleared: 0x0A needs low fix only, 0x05 needs none
    run_op(3'd0, 8'h05, 8'h00, 1'b1, 1'b0);
    #1;
    chk(res_o == 8'h05, "R7 half-carry cleared", {24'b0, res_o}, 8'h05);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule